// File: doc/BRIEF.md
# DRAM ECC Error Logger

This block sits next to the SECDED checker of a DRAM controller and keeps a record of the errors the checker reports. The checker presents one error event per beat on a valid/ready input. Each event carries:

- the error class, single-bit or double-bit;
- the 64-bit data word;
- the received and computed check bytes;
- the chip select, bank, row and column of the access.

The logger keeps a saturating count for each error class and two sets of sticky cause flags. It also holds a capture of the most recent error that qualifies for capture. Software reaches all of this through a 32-bit register port. The port has a write channel and a separate read channel whose data follows the read address combinationally.

The event input never applies back-pressure: `ev_ready` is held high, and an event is taken on every cycle where `ev_valid` is high. The checker therefore needs no buffer in front of the logger. Software sets a single-bit capture threshold in the control register. While the threshold is zero, single-bit errors are counted but never captured. A double-bit error is always captured. Earlier errors remain visible only through the counters. A control bit gates the cause flags onto an alert output.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, every register reads zero and `err_alert` is low.
- R2: Each accepted event adds one to the single-bit count (offset 0x58, `ev_dbl`=0) or to the double-bit count (offset 0x5C, `ev_dbl`=1). A cycle with `ev_valid` low changes no counter, cause flag or capture.
- R3: A counter at its all-ones value (width `CNT_W`, zero-extended on read) stays there on further events.
- R4: Writing zero to a counter offset clears that counter, and writing a nonzero value there has no effect. A clear and an event in the same cycle leave the counter at 1.
- R5: An event sets bit 0 (single-bit) or bit 1 (double-bit) in both cause registers (0xD0 and 0xD8). A write to a cause register clears each bit written as 0 and keeps each bit written as 1. An event in the same cycle as a write still sets its bit.
- R6: A double-bit event always loads the capture. The address word at 0x50 holds the type in bit 0 (1 = double-bit), the chip select in bits 2:1, the column in bits 22:8 and the bank in bits 25:23. Data bits 63:32 read at 0x40 and bits 31:0 read at 0x44.
- R7: The computed-check word at 0x4C holds the computed byte in bits 7:0 and the row in bits 23:8. The received-check word at 0x48 holds the received byte in bits 7:0 and the syndrome (received XOR computed) in bits 15:8. The syndrome is nonzero for every logged event.
- R8: A single-bit event loads the capture only when two conditions hold: the threshold is nonzero, and the single-bit count after that event is at least the threshold. Otherwise the capture keeps its previous contents.
- R9: The control register at 0x54 holds the threshold in bits 23:16 and an alert enable in bit 9. All its other bits read zero. `err_alert` is high exactly when the alert enable is set and any bit of the cause register at 0xD0 is set.
- R10: `ev_ready` is always high. Writes to the capture offsets (0x40 to 0x50) and to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Error event present |
| ev_ready | output | 1 | Event accepted (always high) |
| ev_dbl | input | 1 | 1 = double-bit error, 0 = single-bit error |
| ev_data | input | 64 | Data word of the failing beat |
| ev_rx_ecc | input | 8 | Check byte read from memory |
| ev_calc_ecc | input | 8 | Check byte recomputed from the data |
| ev_cs | input | 2 | Chip select |
| ev_bank | input | 3 | Bank |
| ev_row | input | 16 | Row |
| ev_col | input | 15 | Column |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read byte offset |
| rd_data | output | 32 | Read data for rd_addr |
| err_alert | output | 1 | Enabled cause flag pending |

## Verification
A corrupted counter shows at its offset on the read that follows the next edge. For a saturation fault this read only diverges once the counter reaches its limit, so the bench runs a narrow counter up to that limit. A wrong threshold decision shows as a capture word that either keeps stale fields or takes fields it should have skipped, visible one cycle after the event. A wrong cause-flag merge shows on the next read of the cause offsets, and it shows at once on `err_alert`. Same-cycle collisions of a software write with an event are driven on purpose, because a wrong merge leaves a result that differs by exactly one count or one flag.

// File: rtl/ecclog_pkg.sv
`timescale 1ns/1ps
package ecclog_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int CS_W   = 2;
  localparam int BANK_W = 3;
  localparam int ROW_W  = 16;
  localparam int COL_W  = 15;
  localparam int THR_W  = 8;
  localparam int NCAUSE = 2;

  localparam int OFS_DATA_HI = 'h40;
  localparam int OFS_DATA_LO = 'h44;
  localparam int OFS_RX_CHK  = 'h48;
  localparam int OFS_CALC    = 'h4C;
  localparam int OFS_ADDR    = 'h50;
  localparam int OFS_CTRL    = 'h54;
  localparam int OFS_SBE_CNT = 'h58;
  localparam int OFS_DBE_CNT = 'h5C;
  localparam int OFS_CAUSE_A = 'hD0;
  localparam int OFS_CAUSE_B = 'hD8;

  localparam int CTRL_THR_LSB = 16;
  localparam int CTRL_ALERT_BIT = 9;

  typedef struct packed {
    logic              dbl;
    logic [DATA_W-1:0] data;
    logic [CHK_W-1:0]  rx;
    logic [CHK_W-1:0]  calc;
    logic [CS_W-1:0]   cs;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } ecclog_evt_t;
endpackage

// File: rtl/ecclog_sat_cnt.sv
`timescale 1ns/1ps
module ecclog_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_next
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] base;

  always_comb begin
    base = clr ? '0 : cnt_q;
    if (inc && (base != MAXV)) cnt_next = base + ONE;
    else                       cnt_next = base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

  assign cnt = cnt_q;

  a_r3_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && inc && !clr) |=> (cnt_q == MAXV));
  a_r4_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> (cnt_q == '0));
  a_r4_clear_then_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc) |=> (cnt_q == ONE));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + ONE));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/ecclog_cause.sv
`timescale 1ns/1ps
module ecclog_cause #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] keep_mask,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q;
  logic [N-1:0] kept;

  always_comb kept = wr ? (flags_q & keep_mask) : flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= kept | set;
  end

  assign flags = flags_q;

  a_r5_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((flags_q & $past(set)) == $past(set)));
  a_r5_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ((~keep_mask & ~set) != '0)) |=> ((flags_q & $past(~keep_mask & ~set)) == '0));
  a_r5_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && set == '0) |=> $stable(flags_q));
endmodule

// File: rtl/ecclog_capture.sv
`timescale 1ns/1ps
module ecclog_capture
  import ecclog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  ecclog_evt_t evt,
  output logic [31:0] data_hi,
  output logic [31:0] data_lo,
  output logic [31:0] rx_word,
  output logic [31:0] calc_word,
  output logic [31:0] addr_word
);
  ecclog_evt_t held;

  always_ff @(posedge clk) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= evt;
  end

  logic [CHK_W-1:0] syndrome;
  always_comb syndrome = held.rx ^ held.calc;

  always_comb begin
    data_hi   = held.data[DATA_W-1:32];
    data_lo   = held.data[31:0];
    rx_word   = {16'h0, syndrome, held.rx};
    calc_word = {8'h0, held.row, held.calc};
    addr_word = {6'h0, held.bank, held.col, 5'h0, held.cs, held.dbl};
  end

  a_r6_dbl_marks_type: assert property (@(posedge clk) disable iff (!rst_n)
    (load && evt.dbl) |=> addr_word[0]);
  a_r8_hold_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> ($stable(addr_word) && $stable(calc_word) && $stable(data_lo)));
  a_r7_syndrome_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (load && evt.rx != evt.calc) |=> (rx_word[15:8] != 8'h0));
endmodule

// File: rtl/ecc_err_logger.sv
`timescale 1ns/1ps
module ecc_err_logger
  import ecclog_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_dbl,
  input  logic [63:0]       ev_data,
  input  logic [7:0]        ev_rx_ecc,
  input  logic [7:0]        ev_calc_ecc,
  input  logic [1:0]        ev_cs,
  input  logic [2:0]        ev_bank,
  input  logic [15:0]       ev_row,
  input  logic [14:0]       ev_col,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              err_alert
);
  localparam int NCNT = 2;  // index 0: single-bit, 1: double-bit

  assign ev_ready = 1'b1;

  logic accept, sbe_ev, dbe_ev;
  always_comb begin
    accept = ev_valid && ev_ready;
    sbe_ev = accept && !ev_dbl;
    dbe_ev = accept && ev_dbl;
  end

  ecclog_evt_t evt;
  always_comb begin
    evt.dbl  = ev_dbl;
    evt.data = ev_data;
    evt.rx   = ev_rx_ecc;
    evt.calc = ev_calc_ecc;
    evt.cs   = ev_cs;
    evt.bank = ev_bank;
    evt.row  = ev_row;
    evt.col  = ev_col;
  end

  // control register
  logic [THR_W-1:0] thr_q;
  logic             alert_en_q;
  logic             ctrl_hit;
  always_comb ctrl_hit = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q      <= '0;
      alert_en_q <= 1'b0;
    end else if (ctrl_hit) begin
      thr_q      <= wr_data[CTRL_THR_LSB +: THR_W];
      alert_en_q <= wr_data[CTRL_ALERT_BIT];
    end
  end

  // counters
  logic [CNT_W-1:0] cnt      [NCNT];
  logic [CNT_W-1:0] cnt_next [NCNT];
  logic [NCNT-1:0]  cnt_inc;
  always_comb cnt_inc = {dbe_ev, sbe_ev};

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
    localparam int OFS = (gi == 0) ? OFS_SBE_CNT : OFS_DBE_CNT;
    logic clr;
    always_comb clr = wr_en && (wr_addr == ADDR_W'(OFS)) && (wr_data == 32'h0);
    ecclog_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .inc      (cnt_inc[gi]),
      .cnt      (cnt[gi]),
      .cnt_next (cnt_next[gi])
    );
  end

  // cause flag registers
  logic [NCAUSE-1:0] cause [2];
  for (genvar gc = 0; gc < 2; gc++) begin : g_cause
    localparam int OFS = (gc == 0) ? OFS_CAUSE_A : OFS_CAUSE_B;
    logic hit;
    always_comb hit = wr_en && (wr_addr == ADDR_W'(OFS));
    ecclog_cause #(.N(NCAUSE)) u_cause (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (hit),
      .keep_mask (wr_data[NCAUSE-1:0]),
      .set       (cnt_inc),
      .flags     (cause[gc])
    );
  end

  // capture qualification
  logic sbe_qual, cap_load;
  always_comb begin
    sbe_qual = sbe_ev && (thr_q != '0) && (32'(cnt_next[0]) >= 32'(thr_q));
    cap_load = dbe_ev || sbe_qual;
  end

  logic [31:0] cap_hi, cap_lo, cap_rx, cap_calc, cap_addr;
  ecclog_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cap_load),
    .evt       (evt),
    .data_hi   (cap_hi),
    .data_lo   (cap_lo),
    .rx_word   (cap_rx),
    .calc_word (cap_calc),
    .addr_word (cap_addr)
  );

  always_comb err_alert = alert_en_q && (cause[0] != '0);

  // read mux
  always_comb begin
    rd_data = 32'h0;
    case (rd_addr)
      ADDR_W'(OFS_DATA_HI): rd_data = cap_hi;
      ADDR_W'(OFS_DATA_LO): rd_data = cap_lo;
      ADDR_W'(OFS_RX_CHK):  rd_data = cap_rx;
      ADDR_W'(OFS_CALC):    rd_data = cap_calc;
      ADDR_W'(OFS_ADDR):    rd_data = cap_addr;
      ADDR_W'(OFS_CTRL): begin
        rd_data[CTRL_THR_LSB +: THR_W] = thr_q;
        rd_data[CTRL_ALERT_BIT]        = alert_en_q;
      end
      ADDR_W'(OFS_SBE_CNT): rd_data = 32'(cnt[0]);
      ADDR_W'(OFS_DBE_CNT): rd_data = 32'(cnt[1]);
      ADDR_W'(OFS_CAUSE_A): rd_data = 32'(cause[0]);
      ADDR_W'(OFS_CAUSE_B): rd_data = 32'(cause[1]);
      default:              rd_data = 32'h0;
    endcase
  end

  a_r8_thr_zero_no_sbe_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == '0 && !dbe_ev) |=> $stable(cap_addr));
  a_r10_capture_not_writable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_load) |=> $stable(cap_hi));
  a_r9_alert_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_alert |-> (g_cause[0].u_cause.flags != '0));
endmodule

// File: tb/test_ecc_err_logger.sv
`timescale 1ns/1ps
module test_ecc_err_logger;
  localparam int AW = 12;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        ev_valid = 0, ev_dbl = 0;
  logic        ev_ready;
  logic [63:0] ev_data = '0;
  logic [7:0]  ev_rx_ecc = '0, ev_calc_ecc = '0;
  logic [1:0]  ev_cs = '0;
  logic [2:0]  ev_bank = '0;
  logic [15:0] ev_row = '0;
  logic [14:0] ev_col = '0;
  logic        wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        err_alert;

  ecc_err_logger #(.CNT_W(CW), .ADDR_W(AW)) i_ecc_err_logger (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_dbl(ev_dbl), .ev_data(ev_data), .ev_rx_ecc(ev_rx_ecc),
    .ev_calc_ecc(ev_calc_ecc), .ev_cs(ev_cs), .ev_bank(ev_bank),
    .ev_row(ev_row), .ev_col(ev_col), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .err_alert(err_alert)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [31:0]   exp;
    string         tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit mon_busy = 0;

  // monitor: pops one expected read per cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        mon_busy = 1;
        it = q.pop_front();
        rd_addr = it.addr;
        #1;
        checks++;
        if (rd_data !== it.exp) begin
          fails++;
          $display("FAIL %s: offset 0x%0h actual 0x%08h expected 0x%08h",
                   it.tag, it.addr, rd_data, it.exp);
        end
        mon_busy = 0;
      end
    end
  end

  task automatic expect_reg(input int a, input logic [31:0] e, input string tag);
    item_t it;
    it.addr = AW'(a);
    it.exp  = e;
    it.tag  = tag;
    q.push_back(it);
    wait (q.size() == 0 && !mon_busy);
  endtask

  task automatic expect_pin(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, e);
    end
  endtask

  task automatic set_ev(input logic d, input logic [63:0] data, input logic [7:0] rx,
                        input logic [7:0] calc, input logic [1:0] cs,
                        input logic [2:0] bank, input logic [15:0] row,
                        input logic [14:0] col);
    ev_dbl = d; ev_data = data; ev_rx_ecc = rx; ev_calc_ecc = calc;
    ev_cs = cs; ev_bank = bank; ev_row = row; ev_col = col;
  endtask

  task automatic pulse(input logic ev, input logic wr, input int a, input logic [31:0] d);
    @(negedge clk);
    ev_valid = ev; wr_en = wr; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    ev_valid = 0; wr_en = 0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    expect_reg('h58, 0, "R1 sbe count");
    expect_reg('h5C, 0, "R1 dbe count");
    expect_reg('h50, 0, "R1 addr word");
    expect_reg('h54, 0, "R1 ctrl");
    expect_reg('hD0, 0, "R1 cause A");
    expect_pin(err_alert, 0, "R1 alert");
    expect_pin(ev_ready, 1, "R10 ready");

    // R8 threshold zero: counted but not captured
    set_ev(0, 64'hAAAA_BBBB_CCCC_DDDD, 8'h11, 8'h22, 2'd1, 3'd1, 16'h1, 15'h1);
    pulse(1, 0, 0, 0);
    expect_reg('h58, 1, "R2 sbe count after one");
    expect_reg('h50, 0, "R8 no capture with zero threshold");
    expect_reg('hD0, 1, "R5 cause A sbe bit");
    expect_reg('hD8, 1, "R5 cause B sbe bit");

    // R9 control register
    pulse(0, 1, 'h54, 32'hFFFF_FFFF);
    expect_reg('h54, 32'h00FF_0200, "R9 ctrl reserved bits");
    pulse(0, 1, 'h54, 32'h0001_0200);
    expect_reg('h54, 32'h0001_0200, "R9 ctrl readback");
    expect_pin(err_alert, 1, "R9 alert with flag and enable");

    // SBE capture with threshold 1
    set_ev(0, 64'h0123_4567_89AB_CDEF, 8'h5A, 8'h3C, 2'd2, 3'd5, 16'hBEEF, 15'h1234);
    pulse(1, 0, 0, 0);
    expect_reg('h50, 32'h0292_3404, "R6 addr word sbe");
    expect_reg('h4C, 32'h00BE_EF3C, "R7 calc word");
    expect_reg('h48, 32'h0000_665A, "R7 rx word with syndrome");
    expect_reg('h40, 32'h0123_4567, "R6 data hi");
    expect_reg('h44, 32'h89AB_CDEF, "R6 data lo");
    expect_reg('h58, 2, "R2 sbe count two");

    // DBE capture
    set_ev(1, 64'hFFFF_0000_A5A5_A5A5, 8'h01, 8'h80, 2'd1, 3'd3, 16'h0012, 15'h7FFF);
    pulse(1, 0, 0, 0);
    expect_reg('h50, 32'h01FF_FF03, "R6 addr word dbe");
    expect_reg('h4C, 32'h0000_1280, "R7 calc word dbe");
    expect_reg('h48, 32'h0000_8101, "R7 rx word dbe");
    expect_reg('h5C, 1, "R2 dbe count");
    expect_reg('hD0, 3, "R5 cause A both");

    // R8 threshold 4, alert disabled
    pulse(0, 1, 'h54, 32'h0004_0000);
    expect_pin(err_alert, 0, "R9 alert disabled");
    set_ev(0, 64'h5555, 8'h0F, 8'hF0, 2'd3, 3'd2, 16'h7, 15'h9);
    pulse(1, 0, 0, 0);
    expect_reg('h50, 32'h01FF_FF03, "R8 below threshold keeps capture");
    set_ev(0, 64'h11, 8'hFF, 8'h00, 2'd0, 3'd0, 16'h1, 15'h1);
    pulse(1, 0, 0, 0);
    expect_reg('h50, 32'h0000_0100, "R8 at threshold captures");
    expect_reg('h48, 32'h0000_FFFF, "R7 syndrome nonzero");
    expect_reg('h58, 4, "R2 sbe count four");

    // R5 cause write semantics
    pulse(0, 1, 'hD0, 32'hFFFF_FFFE);
    expect_reg('hD0, 2, "R5 zero bit clears, one bit keeps");
    expect_reg('hD8, 3, "R5 other cause untouched");
    pulse(0, 1, 'hD8, 32'h0);
    expect_reg('hD8, 0, "R5 cause B cleared");

    // R4 counter writes
    pulse(0, 1, 'h58, 32'h5);
    expect_reg('h58, 4, "R4 nonzero write ignored");
    pulse(0, 1, 'h58, 32'h0);
    expect_reg('h58, 0, "R4 zero write clears");

    // R10 write to capture offset ignored
    pulse(0, 1, 'h50, 32'hDEAD_BEEF);
    expect_reg('h50, 32'h0000_0100, "R10 capture write ignored");

    // R3 saturation of the double-bit counter
    set_ev(1, 64'h0, 8'h10, 8'h11, 2'd3, 3'd7, 16'hFFFF, 15'h0);
    for (int i = 0; i < 16; i++) pulse(1, 0, 0, 0);
    expect_reg('h5C, 15, "R3 dbe saturates");
    expect_reg('h50, 32'h0380_0007, "R6 addr word latest dbe");

    // R4 same-cycle clear and event
    @(negedge clk);
    ev_valid = 1; wr_en = 1; wr_addr = AW'('h5C); wr_data = 0;
    @(negedge clk);
    ev_valid = 0; wr_en = 0;
    expect_reg('h5C, 1, "R4 clear then increment");

    // R5 same-cycle cause clear and event
    set_ev(0, 64'h0, 8'h01, 8'h02, 2'd0, 3'd0, 16'h0, 15'h0);
    pulse(1, 1, 'hD0, 32'h0);
    expect_reg('hD0, 1, "R5 event wins over clear");
    expect_reg('h58, 1, "R2 sbe count after clear");
    expect_reg('h50, 32'h0380_0007, "R8 below threshold after clear");

    // R2 invalid cycle has no effect
    set_ev(1, 64'h1234, 8'h33, 8'h44, 2'd2, 3'd2, 16'h2, 15'h2);
    @(negedge clk);
    ev_valid = 0;
    @(negedge clk);
    expect_reg('h5C, 1, "R2 idle cycle keeps dbe count");
    expect_reg('h50, 32'h0380_0007, "R2 idle cycle keeps capture");

    finish_run();
  end
endmodule